// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the arithmetic/logic execute stage of a 32-bit integer core. Each accepted instruction carries a 5-bit operation code, a destination register index, a first operand, an already shifted second operand and the carry that came out of the shifter. One clock later the block presents the result, a register write-enable, the destination index and the condition flags. The flags are negative, zero, carry and overflow.

The block holds the four condition flags itself. An add-with-carry or subtract-with-carry instruction issued in the very next cycle sees the flags left by the one before it. Shifter operand generation, operand fetch and memory instructions are handled elsewhere.

Top module: `dp_exec`

## Requirements
- R1: `code_i[4:1]` selects the operation and `code_i[0]` is the flag-setting (S) bit. The operation encodings are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The logical results are A&B, A^B, A|B, B, A&~B and ~B.
- R2: SUB and CMP compute A−B. RSB computes B−A. ADD and CMN compute A+B.
- R3: ADC computes A+B+C. SBC computes A−B−(1−C). RSC computes B−A−(1−C). C is the carry flag currently held in the block.
- R4: A flag-setting logical operation sets N to result bit 31 and Z when the result is zero. It sets C to `shc_i` and leaves V unchanged.
- R5: A flag-setting add-type operation sets C to the unsigned carry-out and V to signed add overflow. A flag-setting subtract-type operation sets C to not-borrow and V to signed subtract overflow. N and Z follow the result.
- R6: An operation with `code_i[0]`=0 never changes `flags_o` and never raises `flags_valid_o`.
- R7: TST, TEQ, CMP and CMN never assert `we_o`. With the S bit set they update the flags, even when the destination is 15.
- R8: A flag-setting non-compare operation with destination 15 asserts `we_o` and `restore_o`. It does not update the flags and `flags_valid_o` stays low.
- R9: While `rst_ni` is low, every output is zero, the flags included.
- R10: Results appear exactly one cycle after `valid_i`, qualified by a one-cycle `valid_o`. Idle cycles produce no `valid_o`, `we_o`, `flags_valid_o` or `restore_o`.
- R11: Flags written by an instruction are used as carry-in by the instruction accepted in the following cycle. `flags_o` bit order is {N,Z,C,V}, with N at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| code_i | input | 5 | Operation in bits 4:1, S bit in bit 0 |
| rd_i | input | 4 | Destination register index |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Operation result |
| we_o | output | 1 | Destination write-enable |
| rd_o | output | 4 | Destination register index |
| flags_o | output | 4 | Current flags {N,Z,C,V} |
| flags_valid_o | output | 1 | Flags updated by this result |
| restore_o | output | 1 | Request to restore status instead of flag update |

## Verification
The hardest case to reach is a flag that must survive an instruction that does not write it. V has to be unchanged through a logical flag-setting operation, and all flags have to be unchanged through a restore request or a non-S operation. Such a case only proves something if that flag was first driven to an unusual value. The stimulus therefore sets V=1 with a signed add overflow, then issues a logical S-form and a destination-15 S-form directly after it. A carry-chained pair is issued back-to-back to show the carry reaching the next instruction without a gap.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dp_flags_t;

  localparam int unsigned CODE_W = 5;
endpackage

// File: rtl/dp_alu.sv
module dp_alu
  import dp_exec_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  dp_op_e         op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           shc_i,
  input  dp_flags_t      cur_i,
  output logic [DW-1:0]  res_o,
  output dp_flags_t      nxt_o
);
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0] x, y;
  logic          ci;
  logic          is_logic;
  logic [DW:0]   sum;

  always_comb begin
    x        = a_i;
    y        = b_i;
    ci       = 1'b0;
    is_logic = 1'b0;
    res_o    = '0;
    unique case (op_i)
      OP_AND, OP_TST: begin res_o = a_i & b_i;  is_logic = 1'b1; end
      OP_EOR, OP_TEQ: begin res_o = a_i ^ b_i;  is_logic = 1'b1; end
      OP_ORR:         begin res_o = a_i | b_i;  is_logic = 1'b1; end
      OP_MOV:         begin res_o = b_i;        is_logic = 1'b1; end
      OP_BIC:         begin res_o = a_i & ~b_i; is_logic = 1'b1; end
      OP_MVN:         begin res_o = ~b_i;       is_logic = 1'b1; end
      OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1; end
      OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1; end
      OP_ADD, OP_CMN: begin ci = 1'b0; end
      OP_ADC:         begin ci = cur_i.c; end
      OP_SBC:         begin y = ~b_i; ci = cur_i.c; end
      OP_RSC:         begin x = b_i; y = ~a_i; ci = cur_i.c; end
      default: ;
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    if (!is_logic) res_o = sum[DW-1:0];
  end

  // subtraction is x + ~y + ci, so bit DW is already the not-borrow
  always_comb begin
    nxt_o.n = res_o[MSB];
    nxt_o.z = (res_o == '0);
    if (is_logic) begin
      nxt_o.c = shc_i;
      nxt_o.v = cur_i.v;
    end else begin
      nxt_o.c = sum[DW];
      nxt_o.v = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end
  end
endmodule

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import dp_exec_pkg::*;
#(
  parameter int unsigned       RW     = 4,
  parameter logic [RW-1:0]     PC_IDX = '1
) (
  input  logic          valid_i,
  input  dp_op_e        op_i,
  input  logic          s_i,
  input  logic [RW-1:0] rd_i,
  output logic          we_o,
  output logic          flag_ld_o,
  output logic          restore_o
);
  logic is_cmp;

  always_comb begin
    is_cmp    = (op_i inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
    we_o      = valid_i && !is_cmp;
    restore_o = valid_i && s_i && !is_cmp && (rd_i == PC_IDX);
    flag_ld_o = valid_i && s_i && !restore_o;
  end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
  import dp_exec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ld_i,
  input  dp_flags_t d_i,
  output dp_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/dp_exec.sv
module dp_exec
  import dp_exec_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [RW-1:0]       rd_i,
  input  logic [DW-1:0]       opa_i,
  input  logic [DW-1:0]       opb_i,
  input  logic                shc_i,
  output logic                valid_o,
  output logic [DW-1:0]       result_o,
  output logic                we_o,
  output logic [RW-1:0]       rd_o,
  output logic [3:0]          flags_o,
  output logic                flags_valid_o,
  output logic                restore_o
);
  localparam logic [RW-1:0] PC_IDX = '1;

  dp_op_e        op;
  dp_flags_t     cur_f, nxt_f;
  logic [DW-1:0] res;
  logic          we, flag_ld, rstr;

  assign op = dp_op_e'(code_i[CODE_W-1:1]);

  dp_alu #(.DW(DW)) u_alu (
    .op_i (op), .a_i (opa_i), .b_i (opb_i), .shc_i (shc_i),
    .cur_i(cur_f), .res_o(res), .nxt_o(nxt_f)
  );

  dp_ctrl #(.RW(RW), .PC_IDX(PC_IDX)) u_ctrl (
    .valid_i(valid_i), .op_i(op), .s_i(code_i[0]), .rd_i(rd_i),
    .we_o(we), .flag_ld_o(flag_ld), .restore_o(rstr)
  );

  dp_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(flag_ld), .d_i(nxt_f), .q_o(cur_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      result_o      <= '0;
      we_o          <= 1'b0;
      rd_o          <= '0;
      flags_valid_o <= 1'b0;
      restore_o     <= 1'b0;
    end else begin
      valid_o       <= valid_i;
      result_o      <= valid_i ? res : '0;
      we_o          <= we;
      rd_o          <= valid_i ? rd_i : '0;
      flags_valid_o <= flag_ld;
      restore_o     <= rstr;
    end
  end

  assign flags_o = cur_f;

  a_r6_even_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !code_i[0] |=> !flags_valid_o && $stable(flags_o));

  a_r7_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (code_i[4:3] == 2'b10) |=> !we_o);

  a_r8_restore_holds_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> we_o && !flags_valid_o && $stable(flags_o));

  a_r4_logic_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && code_i[0] && (code_i[4:1] inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
    |=> $stable(flags_o[0]));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !we_o && !flags_valid_o && !restore_o);

  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/dp_exec_bench.sv
module dp_exec_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  rd;
    logic [3:0]  fl;
    logic        fv;
    logic        rs;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  code = '0;
  logic [3:0]  rd = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        shc = 1'b0;
  logic        valid_o, we_o, fv_o, rs_o;
  logic [31:0] result_o;
  logic [3:0]  rd_o, flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];
  logic [3:0] mf = 4'b0000; // model flags {N,Z,C,V}

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_exec u_dp_exec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .code_i(code), .rd_i(rd),
    .opa_i(opa), .opb_i(opb), .shc_i(shc), .valid_o(valid_o), .result_o(result_o),
    .we_o(we_o), .rd_o(rd_o), .flags_o(flags_o), .flags_valid_o(fv_o), .restore_o(rs_o)
  );

  task automatic issue(input int op, input bit s, input logic [3:0] d,
                       input logic [31:0] a, input logic [31:0] b, input bit sc,
                       input string req);
    exp_t e;
    logic [31:0] r;
    logic        c, v;
    bit          lg, cmp;
    logic [63:0] w;
    longint      sr;
    bit          cin;
    cin = mf[1];
    lg = 0; c = 0; v = 0;
    case (op)
      0, 8:  begin r = a & b;  lg = 1; end
      1, 9:  begin r = a ^ b;  lg = 1; end
      12:    begin r = a | b;  lg = 1; end
      13:    begin r = b;      lg = 1; end
      14:    begin r = a & ~b; lg = 1; end
      15:    begin r = ~b;     lg = 1; end
      4, 11, 5: begin
        w  = {32'd0, a} + {32'd0, b} + ((op == 5) ? 64'(cin) : 64'd0);
        r  = w[31:0]; c = w[32];
        sr = longint'($signed(a)) + longint'($signed(b)) + ((op == 5) ? longint'(cin) : 0);
        v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      default: begin
        logic [31:0] p, m;
        longint brw;
        p = (op == 3 || op == 7) ? b : a;
        m = (op == 3 || op == 7) ? a : b;
        brw = (op == 6 || op == 7) ? longint'(!cin) : 0;
        r  = p - m - 32'(brw);
        c  = ({32'd0, p} >= ({32'd0, m} + 64'(brw)));
        sr = longint'($signed(p)) - longint'($signed(m)) - brw;
        v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
    endcase
    cmp = (op >= 8 && op <= 11);
    e.res = r; e.rd = d; e.req = req;
    e.we = !cmp;
    e.rs = s && !cmp && (d == 4'd15);
    e.fv = s && !e.rs;
    if (e.fv) mf = {r[31], (r == 0), lg ? sc : c, lg ? mf[0] : v};
    e.fl = mf;
    @(negedge clk);
    valid = 1'b1; code = {4'(op), s}; rd = d; opa = a; opb = b; shc = sc;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid = 1'b0; code = '0; rd = '0; opa = '0; opb = '0; shc = 1'b0;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rst_n && valid_o) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected valid_o: act=1 exp=0");
        end else begin
          e = q.pop_front();
          if (result_o !== e.res || we_o !== e.we || rd_o !== e.rd ||
              flags_o !== e.fl || fv_o !== e.fv || rs_o !== e.rs) begin
            fails++;
            $display("FAIL %s act res=%h we=%b rd=%0d fl=%b fv=%b rs=%b exp res=%h we=%b rd=%0d fl=%b fv=%b rs=%b",
                     e.req, result_o, we_o, rd_o, flags_o, fv_o, rs_o,
                     e.res, e.we, e.rd, e.fl, e.fv, e.rs);
          end
        end
      end else if (rst_n && (we_o || fv_o || rs_o)) begin
        checks++; fails++;
        $display("FAIL R10 strobes while idle: we=%b fv=%b rs=%b exp 000", we_o, fv_o, rs_o);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++; // R9 reset state
    if ({valid_o, we_o, fv_o, rs_o, flags_o, rd_o} !== '0 || result_o !== '0) begin
      fails++;
      $display("FAIL R9 reset outputs act res=%h fl=%b exp all zero", result_o, flags_o);
    end
    rst_n = 1'b1;
    idle(2);
    // logical S-form with zero result and shifter carry
    issue(13, 1, 4'd1, 32'h0, 32'h0, 1, "R4 MOVS zero");
    // signed overflow sets V, then logical S must keep V
    issue(4, 1, 4'd2, 32'h7fffffff, 32'h1, 0, "R5 ADDS overflow");
    issue(0, 1, 4'd3, 32'hffffffff, 32'h80000000, 0, "R4 ANDS keeps V");
    issue(1, 1, 4'd15, 32'h1234, 32'h1, 1, "R8 EORS pc restore");
    issue(2, 0, 4'd4, 32'h10, 32'h3, 1, "R6 SUB no S");
    issue(2, 1, 4'd4, 32'h5, 32'h5, 0, "R5 SUBS equal");
    issue(2, 1, 4'd5, 32'h0, 32'h1, 0, "R5 SUBS borrow");
    issue(3, 1, 4'd6, 32'h3, 32'ha, 0, "R2 RSBS");
    idle(2);
    // carry chain back-to-back
    issue(4, 1, 4'd7, 32'hffffffff, 32'h1, 0, "R5 ADDS carry");
    issue(5, 0, 4'd7, 32'h0, 32'h0, 0, "R11 ADC uses C");
    issue(6, 1, 4'd8, 32'ha, 32'h3, 0, "R3 SBCS C=1");
    issue(2, 1, 4'd8, 32'h1, 32'h2, 0, "R5 SUBS borrow again");
    issue(6, 1, 4'd8, 32'ha, 32'h3, 0, "R3 SBCS C=0");
    issue(7, 1, 4'd9, 32'h3, 32'ha, 0, "R3 RSCS");
    issue(10, 1, 4'd15, 32'h80000000, 32'h1, 0, "R7 CMP pc no write");
    issue(11, 1, 4'd0, 32'h80000000, 32'h80000000, 0, "R7 CMN");
    issue(8, 1, 4'd0, 32'hf0, 32'h0f, 1, "R7 TST");
    issue(9, 0, 4'd0, 32'h1, 32'h1, 0, "R6 TEQ no S");
    issue(12, 0, 4'd1, 32'h00f0, 32'h0f00, 0, "R1 ORR");
    issue(14, 1, 4'd2, 32'hff, 32'h0f, 0, "R1 BICS");
    issue(15, 0, 4'd3, 32'h0, 32'h0000ffff, 0, "R1 MVN");
    issue(1, 0, 4'd4, 32'haaaa5555, 32'hffff0000, 0, "R1 EOR");
    issue(9, 1, 4'd0, 32'h5, 32'h5, 0, "R7 TEQS");
    issue(0, 0, 4'd15, 32'hf, 32'h3, 0, "R8 AND pc no S");
    issue(4, 0, 4'd5, 32'h100, 32'h23, 0, "R2 ADD");
    idle(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing results act=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule